// File: doc/BRIEF.md
# System call trap entry unit

This block performs the entry sequence of a system-call trap for a simple in-order processor model. It inspects each decoded instruction word together with the word's address. When the word is a well-formed system-call instruction and the instruction commits, the block does all of the following on one clock edge:

- it saves the running machine-state word and the return address into two save registers;
- it forces a fixed set of state bits to zero;
- it loads the program counter with a trap vector.

The vector is built from a software-written base register and a software-written offset register.

The instruction is context-synchronizing. While a well-formed system call is presented, the block requests a flush of younger in-flight work. When synchronous entry is configured, it does not take the trap until the pipeline reports that all older work is done. A system-call word with a nonzero reserved field is reported on its own output and is not trapped. Other committed instructions simply advance the program counter by 4.

A small write port lets software load the base, offset and state registers. A trap in the same cycle as a write wins, and the write is dropped.

Top module: `syscall_trap_entry`

## Requirements
- R1: A word is a system call when `instr[31:26]` equals 17 and `instr[1]` is 1. Its reserved bits are `instr[25:2]` and `instr[0]`. A system call with all reserved bits zero is well-formed. The trap is taken when `valid`, `commit` and `older_done` are all high for a well-formed system call, and `trap_taken` shows this in the same cycle.
- R2: On a taken trap, `saved_pc` becomes the instruction address plus 4 at the next clock edge.
- R3: On a taken trap, `saved_state` becomes the full value `mstate` had before the edge.
- R4: On a taken trap, `pc` becomes `{vec_prefix[31:16], vec_offset[15:4], 4'b0000}`.
- R5: On a taken trap, `mstate` bits 18, 15, 14, 13, 11, 10, 8, 5 and 4 (mask 0x0004ED30) become 0. Every other bit keeps its value.
- R6: `flush_req` is high whenever `valid` is high with a well-formed system call, whatever the state of `commit`. While `older_done` is low, no trap is taken and `pc`, `saved_pc`, `saved_state` and `mstate` hold.
- R7: A system call with any reserved bit set raises `invalid_form` while `valid` is high. It takes no trap, raises no flush, and leaves `pc`, `saved_pc`, `saved_state` and `mstate` unchanged.
- R8: A committed valid word that is not a system call sets `pc` to its address plus 4 and leaves the save registers unchanged.
- R9: When `wr_en` is high, `wr_sel` selects the register that takes `wr_data` at the next edge: 0 for `vec_prefix`, 1 for `vec_offset`, 2 for `mstate`, and 3 for none.
- R10: When a trap is taken in the same cycle as a write, the write is dropped entirely. The trap results of R2 to R5 apply unchanged.
- R11: A synchronous reset sets every register output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction word and address are valid |
| commit | input | 1 | Instruction commits this cycle |
| older_done | input | 1 | All older work has completed |
| instr | input | 32 | Decoded instruction word |
| instr_addr | input | 32 | Address of the instruction |
| wr_en | input | 1 | Software register write enable |
| wr_sel | input | 2 | Write target: 0 base, 1 offset, 2 state, 3 none |
| wr_data | input | 32 | Write data |
| flush_req | output | 1 | Flush/synchronise request for younger work |
| invalid_form | output | 1 | System call with nonzero reserved bits |
| trap_taken | output | 1 | Trap entry happens at this edge |
| pc | output | 32 | Program counter |
| saved_pc | output | 32 | Saved return address |
| saved_state | output | 32 | Saved machine-state word |
| mstate | output | 32 | Current machine-state word |
| vec_prefix | output | 32 | Vector base register |
| vec_offset | output | 32 | Vector offset register |

## Verification
The assertions assume that reset is held for at least one edge before any checked activity. They also assume that `instr`, `instr_addr` and the control inputs are stable around the clock edge, so that `$past` of the address and state reflects what the trap captured.

The bench drives every input on the falling edge and draws instruction words from a weighted mix of well-formed system calls, reserved-bit violations, opcode-17 words without bit 1, and arbitrary words. It also holds `older_done` low at random, so every trap precondition occurs both met and unmet.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned CALL_OPC = 17;
   localparam int unsigned N_CLR    = 9;

   // State bits cleared on entry, given in MSB-first numbering:
   // wait-enable 13, ext-int 16, privilege 17, fp 18, fpexc0 20,
   // debug-wait 21, fpexc1 23, instr-space 26, data-space 27
   localparam int unsigned CLR_POS_MSB0 [N_CLR] = '{13, 16, 17, 18, 20, 21, 23, 26, 27};

   typedef enum logic [1:0] {
      WSEL_PREFIX = 2'd0,
      WSEL_OFFSET = 2'd1,
      WSEL_STATE  = 2'd2,
      WSEL_NONE   = 2'd3
   } wsel_e;

   function automatic logic bit_cleared(input int unsigned lsb0_pos, input int unsigned width);
      logic hit;
      hit = 1'b0;
      for (int k = 0; k < N_CLR; k++) begin
         if ((width - 1 - CLR_POS_MSB0[k]) == lsb0_pos) hit = 1'b1;
      end
      return hit;
   endfunction

endpackage

// File: rtl/trap_decode.sv
module trap_decode
   import trap_pkg::*;
#(
   parameter int unsigned ILEN  = 32,
   parameter int unsigned OPC_W = 6,
   parameter int unsigned OPC   = CALL_OPC
) (
   input  logic [ILEN-1:0] instr,
   output logic            is_call,
   output logic            bad_form
);
   localparam int unsigned MARK_BIT = 1;
   localparam int unsigned RSV_HI   = ILEN - OPC_W - 1;

   if (OPC_W + 3 > ILEN) begin : g_bad_width
      $error("trap_decode: opcode field too wide for instruction length");
   end

   logic opc_hit;
   logic rsv_set;

   assign opc_hit = (instr[ILEN-1 -: OPC_W] == OPC_W'(OPC)) && instr[MARK_BIT];
   assign rsv_set = (|instr[RSV_HI:MARK_BIT+1]) | instr[0];

   assign is_call  = opc_hit & ~rsv_set;
   assign bad_form = opc_hit &  rsv_set;

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned PFX_W  = 16,
   parameter int unsigned ZERO_W = 4
) (
   input  logic [XLEN-1:0] prefix,
   input  logic [XLEN-1:0] offset,
   output logic [XLEN-1:0] vector
);
   localparam int unsigned OFF_W = XLEN - PFX_W - ZERO_W;

   if (PFX_W + ZERO_W >= XLEN) begin : g_bad_split
      $error("trap_vector: prefix and zero fields leave no offset bits");
   end

   assign vector = {prefix[XLEN-1 -: PFX_W], offset[ZERO_W +: OFF_W], {ZERO_W{1'b0}}};

endmodule

// File: rtl/state_clear.sv
module state_clear
   import trap_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] state_in,
   output logic [XLEN-1:0] state_out
);
   if (XLEN != WORD_W) begin : g_bad_xlen
      $error("state_clear: bit map is defined for a 32-bit state word");
   end

   for (genvar b = 0; b < XLEN; b++) begin : g_bit
      if (bit_cleared(b, XLEN)) begin : g_clr
         assign state_out[b] = 1'b0;
      end else begin : g_keep
         assign state_out[b] = state_in[b];
      end
   end

endmodule

// File: rtl/syscall_trap_entry.sv
module syscall_trap_entry
   import trap_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned ILEN       = 32,
   parameter int unsigned PFX_W      = 16,
   parameter int unsigned ZERO_W     = 4,
   parameter int unsigned INSTR_STEP = 4,
   parameter bit          SYNC_ENTRY = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid,
   input  logic            commit,
   input  logic            older_done,
   input  logic [ILEN-1:0] instr,
   input  logic [XLEN-1:0] instr_addr,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [XLEN-1:0] wr_data,
   output logic            flush_req,
   output logic            invalid_form,
   output logic            trap_taken,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] saved_pc,
   output logic [XLEN-1:0] saved_state,
   output logic [XLEN-1:0] mstate,
   output logic [XLEN-1:0] vec_prefix,
   output logic [XLEN-1:0] vec_offset
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_STEP);

   if (XLEN != WORD_W || ILEN != WORD_W) begin : g_bad_cfg
      $error("syscall_trap_entry: only 32-bit words are supported");
   end

   logic            is_call;
   logic            bad_form;
   logic            older_ok;
   logic            take;
   logic            advance;
   logic [XLEN-1:0] vector;
   logic [XLEN-1:0] state_next;
   wsel_e           sel;

   trap_decode #(.ILEN(ILEN)) u_decode (
      .instr    (instr),
      .is_call  (is_call),
      .bad_form (bad_form)
   );

   trap_vector #(.XLEN(XLEN), .PFX_W(PFX_W), .ZERO_W(ZERO_W)) u_vector (
      .prefix (vec_prefix),
      .offset (vec_offset),
      .vector (vector)
   );

   state_clear #(.XLEN(XLEN)) u_clear (
      .state_in  (mstate),
      .state_out (state_next)
   );

   if (SYNC_ENTRY) begin : g_sync
      assign older_ok = older_done;
   end else begin : g_nosync
      assign older_ok = 1'b1;
   end

   assign sel          = wsel_e'(wr_sel);
   assign flush_req    = valid & is_call;
   assign invalid_form = valid & bad_form;
   assign take         = valid & commit & older_ok & is_call;
   assign trap_taken   = take;
   assign advance      = valid & commit & ~is_call & ~bad_form;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc          <= '0;
         saved_pc    <= '0;
         saved_state <= '0;
         mstate      <= '0;
         vec_prefix  <= '0;
         vec_offset  <= '0;
      end else if (take) begin
         pc          <= vector;
         saved_pc    <= instr_addr + STEP;
         saved_state <= mstate;
         mstate      <= state_next;
      end else begin
         if (advance) pc <= instr_addr + STEP;
         if (wr_en) begin
            case (sel)
               WSEL_PREFIX: vec_prefix <= wr_data;
               WSEL_OFFSET: vec_offset <= wr_data;
               WSEL_STATE:  mstate     <= wr_data;
               default:     ;
            endcase
         end
      end
   end

   // R2: the return address is the trapping instruction's address plus one step
   p_ret_addr_r2: assert property (@(posedge clk) disable iff (rst)
      take |=> saved_pc == $past(instr_addr) + STEP);

   // R3: the saved state is the state seen before entry
   p_save_state_r3: assert property (@(posedge clk) disable iff (rst)
      take |=> saved_state == $past(mstate));

   // R4: the vector keeps its low zero field
   p_vec_align_r4: assert property (@(posedge clk) disable iff (rst)
      take |=> pc[ZERO_W-1:0] == '0);

   // R5: only the listed bits may change on entry, and they end at zero
   p_clear_set_r5: assert property (@(posedge clk) disable iff (rst)
      take |=> ((mstate & 32'h0004ED30) == '0) &&
               ((mstate & ~32'h0004ED30) == ($past(mstate) & ~32'h0004ED30)));

   // R6: no entry while older work is outstanding
   p_wait_older_r6: assert property (@(posedge clk) disable iff (rst)
      (SYNC_ENTRY && !older_done) |-> !trap_taken);

   // R7: a malformed call neither traps nor flushes
   p_bad_no_trap_r7: assert property (@(posedge clk) disable iff (rst)
      invalid_form |-> (!trap_taken && !flush_req));

   // R10: a write cycle that traps leaves the vector registers alone
   p_trap_wins_r10: assert property (@(posedge clk) disable iff (rst)
      (take && wr_en) |=> ($stable(vec_prefix) && $stable(vec_offset)));

endmodule

// File: tb/test_syscall_trap_entry.sv
module test_syscall_trap_entry;

   localparam logic [31:0] CLR_MASK = 32'h0004ED30;
   localparam logic [31:0] CALL_W   = 32'h44000002;

   logic        clk = 1'b0;
   logic        rst;
   logic        valid, commit, older_done, wr_en;
   logic [31:0] instr, instr_addr, wr_data;
   logic [1:0]  wr_sel;
   logic        flush_req, invalid_form, trap_taken;
   logic [31:0] pc, saved_pc, saved_state, mstate, vec_prefix, vec_offset;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;

   logic [31:0] m_pc, m_spc, m_sst, m_st, m_pfx, m_off;

   always #5 clk = ~clk;

   syscall_trap_entry i_syscall_trap_entry (
      .clk, .rst, .valid, .commit, .older_done, .instr, .instr_addr,
      .wr_en, .wr_sel, .wr_data, .flush_req, .invalid_form, .trap_taken,
      .pc, .saved_pc, .saved_state, .mstate, .vec_prefix, .vec_offset
   );

   function automatic bit f_call(input logic [31:0] w);
      return w[31:26] == 6'd17 && w[1] && w[25:2] == '0 && !w[0];
   endfunction

   function automatic bit f_bad(input logic [31:0] w);
      return w[31:26] == 6'd17 && w[1] && (w[25:2] != '0 || w[0]);
   endfunction

   function automatic logic [31:0] f_vec(input logic [31:0] p, input logic [31:0] o);
      return {p[31:16], o[15:4], 4'b0000};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      chk(req, "pc", pc, m_pc);
      chk(req, "saved_pc", saved_pc, m_spc);
      chk(req, "saved_state", saved_state, m_sst);
      chk(req, "mstate", mstate, m_st);
      chk(req, "vec_prefix", vec_prefix, m_pfx);
      chk(req, "vec_offset", vec_offset, m_off);
   endtask

   // one instruction cycle: drive on the falling edge, check combinational
   // outputs, let the rising edge update, compare on the next falling edge
   task automatic step(input logic v, input logic c, input logic d, input logic [31:0] w,
                       input logic [31:0] a, input logic we, input logic [1:0] ws,
                       input logic [31:0] wd, input string req);
      bit t;
      valid = v; commit = c; older_done = d; instr = w; instr_addr = a;
      wr_en = we; wr_sel = ws; wr_data = wd;
      #1;
      t = v && c && d && f_call(w);
      chk("R6", "flush_req", 32'(flush_req), 32'(v && f_call(w)));
      chk("R7", "invalid_form", 32'(invalid_form), 32'(v && f_bad(w)));
      chk("R1", "trap_taken", 32'(trap_taken), 32'(t));
      @(posedge clk);
      if (t) begin
         m_spc = a + 32'd4;
         m_sst = m_st;
         m_st  = m_st & ~CLR_MASK;
         m_pc  = f_vec(m_pfx, m_off);
      end else begin
         if (v && c && !f_call(w) && !f_bad(w)) m_pc = a + 32'd4;
         if (we) begin
            case (ws)
               2'd0: m_pfx = wd;
               2'd1: m_off = wd;
               2'd2: m_st  = wd;
               default: ;
            endcase
         end
      end
      @(negedge clk);
      check_regs(req);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd20250611);
      rst = 1'b1; valid = 0; commit = 0; older_done = 0; instr = '0; instr_addr = '0;
      wr_en = 0; wr_sel = 0; wr_data = '0;
      m_pc = '0; m_spc = '0; m_sst = '0; m_st = '0; m_pfx = '0; m_off = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_regs("R11");

      // R9: program base, offset and state; selector 3 writes nothing
      step(0, 0, 0, '0, '0, 1, 2'd0, 32'hABCD1234, "R9");
      step(0, 0, 0, '0, '0, 1, 2'd1, 32'h0000FFFF, "R9");
      step(0, 0, 0, '0, '0, 1, 2'd2, 32'hFFFFFFFF, "R9");
      step(0, 0, 0, '0, '0, 1, 2'd3, 32'h55555555, "R9");
      // R6: pending call, older work not done: flush high, nothing changes
      step(1, 1, 0, CALL_W, 32'h00001000, 0, 0, '0, "R6");
      // R1 R2 R3 R4 R5: trap with all state bits set
      step(1, 1, 1, CALL_W, 32'h00001000, 0, 0, '0, "R5");
      chk("R4", "pc vector", pc, 32'hABCDFFF0);
      chk("R5", "mstate cleared", mstate, 32'hFFFB12CF);
      chk("R2", "saved_pc", saved_pc, 32'h00001004);
      chk("R3", "saved_state", saved_state, 32'hFFFFFFFF);
      // R7: reserved bits at each end of the field and bit 0
      step(1, 1, 1, CALL_W | 32'h00000001, 32'h00002000, 0, 0, '0, "R7");
      step(1, 1, 1, CALL_W | 32'h00000004, 32'h00002000, 0, 0, '0, "R7");
      step(1, 1, 1, CALL_W | 32'h02000000, 32'h00002000, 0, 0, '0, "R7");
      // R8: ordinary commit, and opcode 17 without the marker bit
      step(1, 1, 1, 32'h7C000000, 32'h00003000, 0, 0, '0, "R8");
      step(1, 1, 1, 32'h44000000, 32'h00003100, 0, 0, '0, "R8");
      // R10: trap and a base write in the same cycle
      step(0, 0, 0, '0, '0, 1, 2'd2, 32'h12345678, "R9");
      step(1, 1, 1, CALL_W, 32'h00004000, 1, 2'd0, 32'h99990000, "R10");
      chk("R10", "base kept", vec_prefix, 32'hABCD1234);
      // R6: call presented without commit still flushes, no trap
      step(1, 0, 1, CALL_W, 32'h00005000, 0, 0, '0, "R6");

      for (int i = 0; i < 600; i++) begin
         logic [31:0] w;
         int unsigned k;
         k = $urandom % 8;
         case (k)
            0, 1, 2: w = CALL_W;
            3: w = CALL_W | (32'h1 << (2 + $urandom % 24));
            4: w = CALL_W | 32'h1;
            5: w = {6'd17, $urandom} & 32'hFFFFFFFD;
            default: w = $urandom;
         endcase
         step($urandom % 8 != 0, $urandom % 4 != 0, $urandom % 3 != 0, w,
              {$urandom} & 32'hFFFFFFFC, $urandom % 3 == 0, 2'($urandom),
              $urandom, "R1");
      end

      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pc = '0; m_spc = '0; m_sst = '0; m_st = '0; m_pfx = '0; m_off = '0;
      check_regs("R11");
      finish_run();
   end

endmodule